// File: doc/BRIEF.md
# SPI FPGA configuration sequencer

This block is a hardware master that loads a bitstream into the configuration SRAM of an FPGA through that device's SPI slave port. A single start request runs the full load sequence. The block pulls the target's active-low reset line and chip select low together and holds them for a minimum time. It then releases reset and checks that the target's configuration-done input has gone low. It keeps select low for a housekeeping interval, and briefly raises select before the image is sent.

Image bytes arrive on a valid/ready byte stream with a last marker. They are shifted out MSB first in SPI mode 0, with select held low for the whole image. After the last bit, the configuration-done input must be high. The block then clocks out whole bytes of zeros so that the loaded design becomes active. Status is reported through a busy flag, a one-cycle done pulse and a 2-bit error code. A request that asks for partial reconfiguration is refused without touching any pin.

All waits are counted in system clock cycles derived from a clock-frequency parameter and rounded up. An SCLK divider that gives a rate outside 1 MHz to 25 MHz stops elaboration.

Top module: `fpga_cfg_seq`

## Requirements
- R1: On a start without the partial flag, reset (`tgt_rst_n_o`) and select (`tgt_cs_n_o`) go low together. Reset stays low for at least ceil(RESET_NS x CLK_HZ / 1e9) clock cycles, and select is low for every cycle in which reset is low.
- R2: If the synchronized done input is high three cycles after reset is released, the run ends with error code 1 (reset failed), no SCLK edge is produced, and busy drops.
- R3: After reset is released, select stays low for at least ceil(HKEEP_US x CLK_HZ / 1e6) cycles. It then goes high for at least one cycle, and no rising SCLK edge occurs before that.
- R4: Data is sent in SPI mode 0. SCLK idles low and is never high while select is high. MOSI changes only while SCLK is low, bits go out MSB first, and rising edges within a byte are 2 x SCLK_DIV cycles apart.
- R5: During streaming, select is held low until the last image byte has been shifted out. `img_ready_o` is high only while the shifter is empty, select is low and SCLK is low, and each accepted byte appears on MOSI exactly once and in order.
- R6: If the done input is low after the last image bit, the run ends with error code 2 (not done) and no activation bits are sent.
- R7: If the done input is high after the last image bit, ceil(WAKE_BITS / 8) bytes of zeros (7 by default) are shifted out. After them, `done_o` is high for exactly one cycle and busy drops.
- R8: A start with `partial_i` high sets error code 3 (unsupported) on the next cycle. Busy stays low and no target pin changes.
- R9: While busy is low, reset is high, select is high and SCLK is low. This holds after reset, after success and after any error.
- R10: A start clears the error code to 0. For a full run, busy is high from the next cycle until the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| start_i | input | 1 | One-cycle request to begin a load, accepted while idle |
| partial_i | input | 1 | Marks the start request as partial reconfiguration |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte is valid |
| img_last_i | input | 1 | Image byte is the final one |
| img_ready_o | output | 1 | Block accepts an image byte this cycle |
| tgt_rst_n_o | output | 1 | Active-low reset to the target |
| tgt_cs_n_o | output | 1 | Active-low SPI select to the target |
| tgt_sclk_o | output | 1 | SPI clock to the target |
| tgt_mosi_o | output | 1 | SPI data to the target |
| tgt_done_i | input | 1 | Configuration-done from the target (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse on a successful load |
| err_o | output | 2 | 0 none, 1 reset failed, 2 not done, 3 unsupported |

## Verification
The bench builds the block with a 100 MHz clock and SCLK_DIV = 2, which is the fastest legal 25 MHz SCLK. This makes each image byte take 32 cycles. RESET_NS stays at 200, which gives a 20-cycle reset phase. HKEEP_US is cut to 2, which shortens housekeeping to 200 cycles. With these values, many complete loads fit in a short run: successful loads of 1, 3 and 5 bytes, a reset failure, a missing done, and a partial request. Each of these outcomes is followed by a fresh start.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_HKEEP,
        ST_GAP,
        ST_STREAM,
        ST_VERIFY,
        ST_WAKE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RESET   = 2'd1,
        ERR_NOTDONE = 2'd2,
        ERR_UNSUP   = 2'd3
    } seq_err_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       mosi_o
);
    localparam int DW = $clog2(DIV) + 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [7:0]    sh;
        logic [2:0]    bits;
        logic [DW-1:0] div;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.active) begin
            if (load_i) begin
                r_d.active = 1'b1;
                r_d.sh     = byte_i;
                r_d.bits   = '0;
                r_d.div    = '0;
                r_d.sclk   = 1'b0;
            end
        end else if (r_q.div == DIV_LAST) begin
            r_d.div  = '0;
            r_d.sclk = ~r_q.sclk;
            if (r_q.sclk) begin
                // falling edge: next bit or end of byte
                if (r_q.bits == 3'd7) begin
                    r_d.active = 1'b0;
                end else begin
                    r_d.sh   = {r_q.sh[6:0], 1'b0};
                    r_d.bits = r_q.bits + 3'd1;
                end
            end
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idle_o = !r_q.active;
    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.sh[7];

    // R4: mode 0, data held while the clock is high
    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R4: clock returns low at the end of every byte
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !sclk_o);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCLK_DIV    = 2,
    parameter int RESET_NS    = 200,
    parameter int HKEEP_US    = 1200,
    parameter int WAKE_BITS   = 49,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] img_data_i,
    input  logic       img_valid_i,
    input  logic       img_last_i,
    output logic       img_ready_o,
    output logic       tgt_rst_n_o,
    output logic       tgt_cs_n_o,
    output logic       tgt_sclk_o,
    output logic       tgt_mosi_o,
    input  logic       tgt_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o
);
    localparam longint RST_CYC_L = (longint'(RESET_NS) * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int     RST_CYC   = (RST_CYC_L < 1) ? 1 : int'(RST_CYC_L);
    localparam int     HK_CYC    = int'((longint'(HKEEP_US) * longint'(CLK_HZ) + 64'd999_999) / 64'd1_000_000);
    localparam int     WAKE_BYTES = (WAKE_BITS + 7) / 8;
    localparam int     CNT_MAX   = (HK_CYC > RST_CYC) ? ((HK_CYC > WAKE_BYTES) ? HK_CYC : WAKE_BYTES)
                                                      : ((RST_CYC > WAKE_BYTES) ? RST_CYC : WAKE_BYTES);
    localparam int     CW        = $clog2(CNT_MAX + 1) + 1;
    localparam int     DONE_CHK  = SYNC_STAGES + 1;
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] HK_LAST   = CW'(HK_CYC - 1);
    localparam logic [CW-1:0] HK_CHK    = CW'(DONE_CHK);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_BYTES);

    // SCLK = CLK_HZ / (2*SCLK_DIV) must lie in 1..25 MHz
    if (longint'(CLK_HZ) > 64'd50_000_000 * longint'(SCLK_DIV) ||
        longint'(CLK_HZ) < 64'd2_000_000 * longint'(SCLK_DIV)) begin : g_bad_div
        $error("fpga_cfg_seq: SCLK_DIV gives an SPI clock outside 1..25 MHz");
    end
    if (HK_CYC <= DONE_CHK) begin : g_bad_hk
        $error("fpga_cfg_seq: housekeeping window shorter than done check point");
    end

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          last_seen;
        logic          done_p;
        seq_err_e      err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      done_s;
    logic      tx_idle, tx_load;
    logic [7:0] tx_byte;
    logic      ready;

    cfg_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .async_i(tgt_done_i), .sync_o(done_s)
    );

    spi_byte_tx #(.DIV(SCLK_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_i(tx_load), .byte_i(tx_byte),
        .idle_o(tx_idle), .sclk_o(tgt_sclk_o), .mosi_o(tgt_mosi_o)
    );

    assign ready = (r_q.st == ST_STREAM) && tx_idle && !r_q.last_seen;

    always_comb begin
        r_d        = r_q;
        r_d.done_p = 1'b0;
        tx_load    = 1'b0;
        tx_byte    = img_data_i;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (partial_i) begin
                        r_d.err = ERR_UNSUP;
                    end else begin
                        r_d.err = ERR_NONE;
                        r_d.st  = ST_RESET;
                        r_d.cnt = '0;
                    end
                end
            end
            ST_RESET: begin
                if (r_q.cnt == RST_LAST) begin
                    r_d.st  = ST_HKEEP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HKEEP: begin
                if (r_q.cnt == HK_CHK && done_s) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = ERR_RESET;
                end else if (r_q.cnt == HK_LAST) begin
                    r_d.st  = ST_GAP;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_GAP: r_d.st = ST_STREAM;
            ST_STREAM: begin
                tx_load = img_valid_i && ready;
                if (tx_load && img_last_i) r_d.last_seen = 1'b1;
                if (r_q.last_seen && tx_idle) begin
                    r_d.st        = ST_VERIFY;
                    r_d.last_seen = 1'b0;
                end
            end
            ST_VERIFY: begin
                if (done_s) begin
                    r_d.st  = ST_WAKE;
                    r_d.cnt = '0;
                end else begin
                    r_d.st  = ST_IDLE;
                    r_d.err = ERR_NOTDONE;
                end
            end
            ST_WAKE: begin
                tx_byte = '0;
                if (tx_idle) begin
                    if (r_q.cnt == WAKE_LAST) begin
                        r_d.st     = ST_IDLE;
                        r_d.done_p = 1'b1;
                    end else begin
                        tx_load = 1'b1;
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, last_seen: 1'b0, done_p: 1'b0, err: ERR_NONE};
        else        r_q <= r_d;
    end

    assign img_ready_o = ready;
    assign tgt_rst_n_o = (r_q.st != ST_RESET);
    assign tgt_cs_n_o  = (r_q.st == ST_IDLE) || (r_q.st == ST_GAP);
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done_p;
    assign err_o       = r_q.err;

    // R1: reset never low without select low
    a_r1_rst_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n_o |-> !tgt_cs_n_o);
    // R4: no clock activity while deselected
    a_r4_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cs_n_o |-> !tgt_sclk_o);
    // R5: ready only with an empty shifter
    a_r5_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready_o |-> (!tgt_sclk_o && !tgt_cs_n_o));
    // R7: done lasts one cycle and ends the run
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && err_o == ERR_NONE) ##1 !done_o);
    // R8: partial request refused without starting
    a_r8_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && partial_i && !busy_o) |=> (err_o == ERR_UNSUP && !busy_o && tgt_cs_n_o));
    // R9: pins parked while idle
    a_r9_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tgt_rst_n_o && tgt_cs_n_o && !tgt_sclk_o));
    // R10: full start clears error and goes busy
    a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !partial_i && !busy_o) |=> (busy_o && err_o == ERR_NONE));
endmodule

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, partial_i = 1'b0;
    logic [7:0] img_data_i = '0;
    logic       img_valid_i = 1'b0, img_last_i = 1'b0;
    logic       img_ready_o, tgt_rst_n_o, tgt_cs_n_o, tgt_sclk_o, tgt_mosi_o;
    logic       tgt_done_i = 1'b0;
    logic       busy_o, done_o;
    logic [1:0] err_o;

    always #5 clk = ~clk;

    fpga_cfg_seq #(
        .CLK_HZ(100_000_000), .SCLK_DIV(2), .RESET_NS(200), .HKEEP_US(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .img_data_i(img_data_i), .img_valid_i(img_valid_i), .img_last_i(img_last_i),
        .img_ready_o(img_ready_o), .tgt_rst_n_o(tgt_rst_n_o), .tgt_cs_n_o(tgt_cs_n_o),
        .tgt_sclk_o(tgt_sclk_o), .tgt_mosi_o(tgt_mosi_o), .tgt_done_i(tgt_done_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int total = 0, bad = 0;
    logic [7:0] exp_q [$];
    logic [7:0] img_buf [16];
    bit expect_rf = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard consumer and pin-timing watcher
    int cyc = 0, rlo = 0, hk = 0, last_rise = 0, bitn = 0;
    bit in_hk = 0, hk_ok = 0, per_ok = 1;
    logic prev_rst = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
    logic [7:0] cur = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!tgt_rst_n_o) begin
                rlo++;
                if (tgt_cs_n_o) chk(0, "R1 select high during reset", 1, 0);
            end
            if (tgt_rst_n_o && !prev_rst) begin
                chk(rlo >= 20, "R1 reset low cycles", rlo, 20);
                rlo = 0; in_hk = 1; hk = 0; hk_ok = 0;
            end
            if (in_hk) begin
                if (!tgt_cs_n_o) hk++;
                else begin
                    if (!expect_rf) chk(hk >= 200, "R3 housekeeping select low", hk, 200);
                    in_hk = 0; hk_ok = 1;
                end
            end
            if (tgt_sclk_o && !prev_sclk) begin
                if (tgt_cs_n_o || !hk_ok || in_hk) chk(0, "R3 sclk edge outside data window", 1, 0);
                if (bitn > 0 && (cyc - last_rise) != 4) per_ok = 0;
                last_rise = cyc;
                cur = {cur[6:0], tgt_mosi_o};
                bitn++;
                if (bitn == 8) begin
                    if (exp_q.size() == 0) chk(0, "R6 unexpected byte on MOSI", int'(cur), -1);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(cur == e && per_ok, "R4/R5/R7 byte on MOSI", int'(cur), int'(e));
                    end
                    bitn = 0; per_ok = 1;
                end
            end
            if (tgt_cs_n_o && tgt_sclk_o) chk(0, "R4 sclk high while deselected", 1, 0);
            if (img_ready_o && (tgt_sclk_o || tgt_cs_n_o)) chk(0, "R5 ready while shifter busy", 1, 0);
            if (done_o) begin
                done_cnt++;
                if (prev_done) chk(0, "R7 done longer than one cycle", 2, 1);
            end
            prev_rst = tgt_rst_n_o; prev_sclk = tgt_sclk_o; prev_done = done_o;
        end
    end

    task automatic pins_idle(input string req);
        chk(tgt_rst_n_o && tgt_cs_n_o && !tgt_sclk_o, req,
            {tgt_rst_n_o, tgt_cs_n_o, tgt_sclk_o}, 3'b110);
    endtask

    // driver: mode 0 success, 1 done stuck high, 2 done never rises
    task automatic run_cfg(input int n, input int mode);
        int d0;
        expect_rf = (mode == 1);
        tgt_done_i = (mode == 1);
        repeat (4) @(negedge clk);
        if (mode != 1) begin
            for (int i = 0; i < n; i++) exp_q.push_back(img_buf[i]);
            if (mode == 0) for (int i = 0; i < 7; i++) exp_q.push_back(8'h00);
        end
        d0 = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && err_o == 2'd0, "R10 start clears error and sets busy", {busy_o, err_o}, 4);
        if (mode != 1) begin
            for (int i = 0; i < n; i++) begin
                img_valid_i = 1'b1; img_data_i = img_buf[i]; img_last_i = (i == n - 1);
                while (!img_ready_o) @(negedge clk);
                @(negedge clk);
            end
            img_valid_i = 1'b0; img_last_i = 1'b0;
            if (mode == 0) tgt_done_i = 1'b1;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
        case (mode)
            0: chk(err_o == 2'd0, "R7 success code", err_o, 0);
            1: chk(err_o == 2'd1, "R2 reset-failure code", err_o, 1);
            default: chk(err_o == 2'd2, "R6 not-done code", err_o, 2);
        endcase
        chk(done_cnt - d0 == ((mode == 0) ? 1 : 0), "R7 done pulse count", done_cnt - d0, (mode == 0) ? 1 : 0);
        chk(exp_q.size() == 0, "R5/R7 all expected bytes shifted", exp_q.size(), 0);
        exp_q.delete();
        pins_idle("R9 pins parked after run");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pins_idle("R9 pins after reset");
        chk(!busy_o && err_o == 2'd0 && !img_ready_o && !done_o, "R9 status after reset",
            {busy_o, err_o, img_ready_o, done_o}, 0);

        // R8: partial request
        start_i = 1'b1; partial_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; partial_i = 1'b0;
        chk(err_o == 2'd3 && !busy_o, "R8 unsupported code", {busy_o, err_o}, 3);
        repeat (20) @(negedge clk);
        pins_idle("R8 pins untouched after partial request");

        img_buf[0] = 8'hA5; img_buf[1] = 8'h3C; img_buf[2] = 8'h00;
        img_buf[3] = 8'hFF; img_buf[4] = 8'h81;
        run_cfg(5, 0);
        run_cfg(2, 1);
        img_buf[0] = 8'h01; img_buf[1] = 8'h80; img_buf[2] = 8'h5A;
        run_cfg(3, 0);
        img_buf[0] = 8'hC3; img_buf[1] = 8'h7E; img_buf[2] = 8'h12; img_buf[3] = 8'hEF;
        run_cfg(4, 2);
        img_buf[0] = 8'h96;
        run_cfg(1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule